// File: doc/BRIEF.md
# Cache Line Range Maintenance Engine

This block carries out a write-back or a discard over a contiguous run of cache lines on behalf of a CPU. Software arms it with two register writes. The first write holds the lower address of the run and picks the operation. The second write holds the upper address and launches the walk. The engine then steps through the lines in ascending order. For each line it sends one command, carrying the line address and the operation, to the cache tag/state logic over a valid/ready port. It holds a stall line toward the CPU until the walk has finished.

Both ends of the run are inclusive, and both are aligned down to a line boundary first. A run must lie inside one page, because the requester translates only one address per run. If the two addresses name different pages, the run is refused and an error flag is raised instead.

Top module: `line_range_engine`

## Requirements
- R1: While reset is held and after it is released, with no writes, `cpu_stall`, `line_cmd_valid` and `range_err` are all 0.
- R2: `reg_wr_sel` bit 0 selects the register (0 = lower address, 1 = upper address) and bit 1 selects the operation (0 = write back, 1 = discard). An upper-address write of the same operation as the last lower-address write launches the run, and `cpu_stall` is 1 in the cycle after the launching write.
- R3: Every line whose aligned address lies between the aligned lower and upper addresses, both ends included, is sent exactly once, in ascending order, in steps of 32 bytes.
- R4: Address bits [4:0] of both written addresses are ignored, and `line_cmd_addr[4:0]` is always 0.
- R5: One command is accepted per cycle in which `line_cmd_valid` and `line_cmd_ready` are both 1. While a command waits for ready, its address and operation stay unchanged, and `line_cmd_valid` is only 1 while `cpu_stall` is 1.
- R6: `cpu_stall` stays 1 for the cycle after the final command is accepted and is 0 in the cycle after that.
- R7: If the aligned upper address is below the aligned lower address, no command is sent, and `cpu_stall` is 1 for exactly one cycle.
- R8: If the two addresses differ in bits [31:12], no command is sent and `cpu_stall` stays 0. `range_err` is 1 from the cycle after that write and returns to 0 in the cycle after the next lower-address write.
- R9: An upper-address write is ignored when no lower-address write of the same operation has occurred since the last launch or reset.
- R10: `line_cmd_op` is 0 for a run launched through the write-back pair and 1 for a run launched through the discard pair.
- R11: Register writes made while `cpu_stall` is 1 are ignored. This includes a lower-address write, which then does not arm a later upper-address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Bit 0: register (0 lower, 1 upper); bit 1: operation (0 write back, 1 discard) |
| reg_wr_data | input | 32 | Byte address written |
| cpu_stall | output | 1 | Holds the requesting CPU while a run is in progress |
| range_err | output | 1 | Last launch was refused for crossing a page |
| line_cmd_valid | output | 1 | Per-line command is present |
| line_cmd_ready | input | 1 | Cache logic takes the command this cycle |
| line_cmd_op | output | 1 | 0 write back, 1 discard |
| line_cmd_addr | output | 32 | Line-aligned address of the command |

## Verification
The bench looks for off-by-one errors at both ends of the inclusive run. One case is a run whose upper address is below its lower address before alignment and equal to it after. A design that compared raw addresses or used an exclusive end would drop or add a line there. It stalls the cache port with irregular ready patterns, so a walker that advanced without a handshake would skip addresses. It also times the stall release cycle by cycle, so an engine that released one cycle early or late would be caught. Page crossings, upper-address writes without arming or with the wrong operation, and writes made during a stall are each shown to leave the outputs quiet, which a design that re-armed or launched anyway would fail.

// File: rtl/rng_pkg.sv
package rng_pkg;

   // Walker control states
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_WALK  = 2'd1,
      WS_DRAIN = 2'd2
   } walk_state_e;

   // Per-line operation code presented on the cache port
   typedef enum logic {
      LOP_WBACK   = 1'b0,
      LOP_DISCARD = 1'b1
   } line_op_e;

   // Position of the register/operation fields in the select input
   localparam int unsigned SEL_REG_BIT = 0;
   localparam int unsigned SEL_OP_BIT  = 1;

endpackage

// File: rtl/rng_arm_regs.sv
// Captures the lower address, tracks arming, and decodes the launch write.
module rng_arm_regs #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LINE_LSB = 5,
   parameter int unsigned PAGE_LSB = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [1:0]                   wr_sel,
   input  logic [ADDR_W-1:LINE_LSB]     wr_line,
   input  logic                         busy,
   output logic                         start_seen,
   output logic                         launch,
   output logic                         refuse,
   output logic                         launch_op,
   output logic [ADDR_W-PAGE_LSB-1:0]   launch_page,
   output logic [PAGE_LSB-LINE_LSB-1:0] launch_first,
   output logic [PAGE_LSB-LINE_LSB-1:0] launch_last,
   output logic                         launch_empty
);
   import rng_pkg::*;

   localparam int unsigned PG_W  = ADDR_W - PAGE_LSB;
   localparam int unsigned OFF_W = PAGE_LSB - LINE_LSB;

   logic                     armed_q;
   logic                     arm_op_q;
   logic [ADDR_W-1:LINE_LSB] lo_line_q;

   logic wr_ok;
   logic is_lo_wr;
   logic is_hi_wr;
   logic hi_matches;
   logic page_cross;

   logic [PG_W-1:0]  lo_page;
   logic [PG_W-1:0]  hi_page;
   logic [OFF_W-1:0] lo_off;
   logic [OFF_W-1:0] hi_off;

   // Writes are only honoured while no run is in progress.
   assign wr_ok    = wr_en && !busy;
   assign is_lo_wr = wr_ok && !wr_sel[SEL_REG_BIT];
   assign is_hi_wr = wr_ok &&  wr_sel[SEL_REG_BIT];

   assign hi_matches = is_hi_wr && armed_q && (arm_op_q == wr_sel[SEL_OP_BIT]);

   assign lo_page = lo_line_q[ADDR_W-1:PAGE_LSB];
   assign hi_page = wr_line[ADDR_W-1:PAGE_LSB];
   assign lo_off  = lo_line_q[PAGE_LSB-1:LINE_LSB];
   assign hi_off  = wr_line[PAGE_LSB-1:LINE_LSB];

   assign page_cross = (lo_page != hi_page);

   assign start_seen   = is_lo_wr;
   assign launch       = hi_matches && !page_cross;
   assign refuse       = hi_matches &&  page_cross;
   assign launch_op    = arm_op_q;
   assign launch_page  = lo_page;
   assign launch_first = lo_off;
   assign launch_last  = hi_off;
   assign launch_empty = (hi_off < lo_off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         arm_op_q  <= 1'b0;
         lo_line_q <= '0;
      end else if (is_lo_wr) begin
         armed_q   <= 1'b1;
         arm_op_q  <= wr_sel[SEL_OP_BIT];
         lo_line_q <= wr_line;
      end else if (hi_matches) begin
         armed_q   <= 1'b0;
      end
   end

endmodule

// File: rtl/rng_walker.sv
// Steps through line offsets inside one page and drives the command port.
module rng_walker #(
   parameter int unsigned PG_W  = 20,
   parameter int unsigned OFF_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             launch_op,
   input  logic [PG_W-1:0]  launch_page,
   input  logic [OFF_W-1:0] launch_first,
   input  logic [OFF_W-1:0] launch_last,
   input  logic             launch_empty,
   input  logic             cmd_ready,
   output logic             cmd_valid,
   output logic             cmd_op,
   output logic [PG_W-1:0]  cmd_page,
   output logic [OFF_W-1:0] cmd_off,
   output logic             busy
);
   import rng_pkg::*;

   walk_state_e      state_q;
   walk_state_e      state_d;
   line_op_e         op_q;
   logic [PG_W-1:0]  page_q;
   logic [OFF_W-1:0] cur_q;
   logic [OFF_W-1:0] last_q;

   logic at_last;
   logic accept;

   assign at_last = (cur_q == last_q);
   assign accept  = (state_q == WS_WALK) && cmd_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE: begin
            if (launch) begin
               state_d = launch_empty ? WS_DRAIN : WS_WALK;
            end
         end
         WS_WALK: begin
            if (cmd_ready && at_last) begin
               state_d = WS_DRAIN;
            end
         end
         WS_DRAIN: begin
            state_d = WS_IDLE;
         end
         default: begin
            state_d = WS_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         op_q    <= LOP_WBACK;
         page_q  <= '0;
         cur_q   <= '0;
         last_q  <= '0;
      end else begin
         state_q <= state_d;
         if ((state_q == WS_IDLE) && launch) begin
            op_q   <= line_op_e'(launch_op);
            page_q <= launch_page;
            cur_q  <= launch_first;
            last_q <= launch_last;
         end else if (accept && !at_last) begin
            cur_q  <= cur_q + OFF_W'(1);
         end
      end
   end

   assign cmd_valid = (state_q == WS_WALK);
   assign cmd_op    = op_q;
   assign cmd_page  = page_q;
   assign cmd_off   = cur_q;
   assign busy      = (state_q != WS_IDLE);

endmodule

// File: rtl/rng_err_flag.sv
// Holds the page-crossing error; the clearing event is chosen by parameter.
module rng_err_flag #(
   parameter bit CLEAR_ON_START = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refuse,
   input  logic start_seen,
   input  logic launch,
   output logic err
);
   logic clr;
   logic err_q;

   generate
      if (CLEAR_ON_START) begin : g_clr_start
         assign clr = start_seen;
      end else begin : g_clr_launch
         assign clr = launch;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (refuse) begin
         err_q <= 1'b1;
      end else if (clr) begin
         err_q <= 1'b0;
      end
   end

   assign err = err_q;

endmodule

// File: rtl/line_range_engine.sv
module line_range_engine #(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned LINE_BYTES     = 32,
   parameter int unsigned PAGE_BYTES     = 4096,
   parameter bit          CLEAR_ON_START = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [ADDR_W-1:0] reg_wr_data,
   output logic              cpu_stall,
   output logic              range_err,
   output logic              line_cmd_valid,
   input  logic              line_cmd_ready,
   output logic              line_cmd_op,
   output logic [ADDR_W-1:0] line_cmd_addr
);
   localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
   localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);
   localparam int unsigned PG_W     = ADDR_W - PAGE_LSB;
   localparam int unsigned OFF_W    = PAGE_LSB - LINE_LSB;

   // Elaboration-time parameter checks
   generate
      if ((1 << LINE_LSB) != LINE_BYTES || LINE_BYTES < 2) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 2");
      end
      if ((1 << PAGE_LSB) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (PAGE_BYTES <= LINE_BYTES) begin : g_bad_ratio
         $error("PAGE_BYTES must exceed LINE_BYTES");
      end
      if (ADDR_W <= PAGE_LSB) begin : g_bad_addr
         $error("ADDR_W must be wider than the page offset");
      end
   endgenerate

   logic              start_seen;
   logic              launch;
   logic              refuse;
   logic              launch_op;
   logic [PG_W-1:0]   launch_page;
   logic [OFF_W-1:0]  launch_first;
   logic [OFF_W-1:0]  launch_last;
   logic              launch_empty;
   logic              busy;
   logic [PG_W-1:0]   cmd_page;
   logic [OFF_W-1:0]  cmd_off;
   logic              unused_low_bits;

   // Byte offset inside a line plays no part in the walk.
   assign unused_low_bits = ^reg_wr_data[LINE_LSB-1:0];

   rng_arm_regs #(
      .ADDR_W   (ADDR_W),
      .LINE_LSB (LINE_LSB),
      .PAGE_LSB (PAGE_LSB)
   ) i_arm (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr_en),
      .wr_sel       (reg_wr_sel),
      .wr_line      (reg_wr_data[ADDR_W-1:LINE_LSB]),
      .busy         (busy),
      .start_seen   (start_seen),
      .launch       (launch),
      .refuse       (refuse),
      .launch_op    (launch_op),
      .launch_page  (launch_page),
      .launch_first (launch_first),
      .launch_last  (launch_last),
      .launch_empty (launch_empty)
   );

   rng_walker #(
      .PG_W  (PG_W),
      .OFF_W (OFF_W)
   ) i_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (launch),
      .launch_op    (launch_op),
      .launch_page  (launch_page),
      .launch_first (launch_first),
      .launch_last  (launch_last),
      .launch_empty (launch_empty),
      .cmd_ready    (line_cmd_ready),
      .cmd_valid    (line_cmd_valid),
      .cmd_op       (line_cmd_op),
      .cmd_page     (cmd_page),
      .cmd_off      (cmd_off),
      .busy         (busy)
   );

   rng_err_flag #(
      .CLEAR_ON_START (CLEAR_ON_START)
   ) i_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .refuse     (refuse),
      .start_seen (start_seen),
      .launch     (launch),
      .err        (range_err)
   );

   assign cpu_stall     = busy;
   assign line_cmd_addr = {cmd_page, cmd_off, {LINE_LSB{1'b0}}};

endmodule

// File: rtl/rng_checker.sv
module rng_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_stall,
   input logic              range_err,
   input logic              line_cmd_valid,
   input logic              line_cmd_ready,
   input logic              line_cmd_op,
   input logic [ADDR_W-1:0] line_cmd_addr
);
   localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);
   localparam int unsigned PAGE_LSB = $clog2(PAGE_BYTES);

   p_valid_in_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmd_valid |-> cpu_stall);

   p_hold_while_waiting_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmd_valid && !line_cmd_ready) |=>
         (line_cmd_valid && $stable(line_cmd_addr) && $stable(line_cmd_op)));

   p_ascending_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmd_valid && line_cmd_ready) |=>
         (!line_cmd_valid || (line_cmd_addr == $past(line_cmd_addr) + ADDR_W'(LINE_BYTES))));

   p_line_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmd_valid |-> (line_cmd_addr[LINE_LSB-1:0] == '0));

   p_one_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmd_valid |=> (!line_cmd_valid ||
         (line_cmd_addr[ADDR_W-1:PAGE_LSB] == $past(line_cmd_addr[ADDR_W-1:PAGE_LSB]))));

   p_drain_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_cmd_valid) && $past(line_cmd_ready)) |-> cpu_stall);

   p_drain_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_cmd_valid) && $past(line_cmd_ready)) |=> !cpu_stall);

   p_refused_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(range_err) |-> !cpu_stall);

endmodule

bind line_range_engine rng_checker #(
   .ADDR_W     (ADDR_W),
   .LINE_BYTES (LINE_BYTES),
   .PAGE_BYTES (PAGE_BYTES)
) i_rng_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_stall      (cpu_stall),
   .range_err      (range_err),
   .line_cmd_valid (line_cmd_valid),
   .line_cmd_ready (line_cmd_ready),
   .line_cmd_op    (line_cmd_op),
   .line_cmd_addr  (line_cmd_addr)
);

// File: tb/test_line_range_engine.sv
`timescale 1ns/1ps
module test_line_range_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'b00;
   logic [31:0] wr_data = '0;
   logic        rdy = 1'b0;
   logic        stall;
   logic        err;
   logic        valid;
   logic        op;
   logic [31:0] addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   line_range_engine i_line_range_engine (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr_en      (wr_en),
      .reg_wr_sel     (wr_sel),
      .reg_wr_data    (wr_data),
      .cpu_stall      (stall),
      .range_err      (err),
      .line_cmd_valid (valid),
      .line_cmd_ready (rdy),
      .line_cmd_op    (op),
      .line_cmd_addr  (addr)
   );

   // {op, ready mode, lower, upper, expected lines, expected error}
   localparam int NVEC = 8;
   localparam logic [75:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 32'h0000_1000, 32'h0000_1060, 8'd4,   1'b0},
      {1'b1, 2'd1, 32'h0000_2004, 32'h0000_201F, 8'd1,   1'b0},
      {1'b0, 2'd2, 32'h0000_3A1F, 32'h0000_3B05, 8'd9,   1'b0},
      {1'b1, 2'd0, 32'h0000_4F80, 32'h0000_4FFF, 8'd4,   1'b0},
      {1'b0, 2'd0, 32'h0000_5100, 32'h0000_50E0, 8'd0,   1'b0},
      {1'b1, 2'd1, 32'h0000_5FE0, 32'h0000_6000, 8'd0,   1'b1},
      {1'b0, 2'd0, 32'h0000_7000, 32'h0000_7FFF, 8'd128, 1'b0},
      {1'b1, 2'd2, 32'h0000_8010, 32'h0000_8005, 8'd1,   1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic pat(input int mode, input int c);
      case (mode)
         0:       pat = 1'b1;
         1:       pat = (c % 2) == 1;
         default: pat = (c % 3) == 2;
      endcase
   endfunction

   task automatic do_write(input logic [1:0] sel, input logic [31:0] data);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
   endtask

   task automatic quiet(input int ncyc, input string req);
      @(posedge clk); #1; wr_en = 1'b0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         chk(!stall && !valid, req, {30'd0, stall, valid}, 32'd0);
      end
   endtask

   // Follows a run launched by the write that the next edge captures.
   task automatic watch(input logic kind, input int mode, input logic [31:0] lo,
                        input int exp_n, input logic exp_err);
      int c = 0;
      int n = 0;
      int la = -1;
      int fl = -1;
      int exp_fl;
      logic [31:0] ea = lo & 32'hFFFF_FFE0;
      @(posedge clk); #1; wr_en = 1'b0; rdy = pat(mode, 0);
      while (c < 400 && fl < 0) begin
         @(negedge clk);
         if (c == 0) begin
            chk(stall == !exp_err, "R2 stall after launch", {31'd0, stall}, {31'd0, !exp_err});
            chk(err == exp_err, "R8 error flag", {31'd0, err}, {31'd0, exp_err});
         end
         if (valid) begin
            chk(addr == ea, "R3 R4 line address", addr, ea);
            chk(op == kind, "R10 operation", {31'd0, op}, {31'd0, kind});
            if (rdy) begin
               n++; ea = ea + 32'd32; la = c;
            end
         end
         if (!stall) fl = c;
         @(posedge clk); #1; rdy = pat(mode, c + 1);
         c++;
      end
      chk(n == exp_n, "R3 line count", n, exp_n);
      if (exp_err) exp_fl = 0;
      else if (exp_n == 0) exp_fl = 1;
      else exp_fl = la + 2;
      chk(fl == exp_fl, "R6 R7 stall release cycle", fl, exp_fl);
      rdy = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!stall && !valid && !err, "R1 in reset", {29'd0, stall, valid, err}, 32'd0);
      @(posedge clk); #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!stall && !valid && !err, "R1 after reset", {29'd0, stall, valid, err}, 32'd0);

      // R9: upper write with nothing armed
      do_write(2'b01, 32'h0000_9040);
      quiet(4, "R9 unarmed upper write");

      // R9: operation mismatch, then the matching write launches
      do_write(2'b00, 32'h0000_9000);
      do_write(2'b11, 32'h0000_9040);
      quiet(3, "R9 mismatched upper write");
      do_write(2'b01, 32'h0000_9040);
      watch(1'b0, 0, 32'h0000_9000, 3, 1'b0);

      // Table of runs: R2 R3 R4 R6 R7 R8 R10
      for (int v = 0; v < NVEC; v++) begin
         do_write({VEC[v][75], 1'b0}, VEC[v][72:41]);
         do_write({VEC[v][75], 1'b1}, VEC[v][40:9]);
         watch(VEC[v][75], int'(VEC[v][74:73]), VEC[v][72:41],
               int'(VEC[v][8:1]), VEC[v][0]);
      end

      // R11: a lower write during a stall does not arm
      do_write(2'b00, 32'h0000_A000);
      do_write(2'b01, 32'h0000_A0E0);
      @(posedge clk); #1; wr_en = 1'b0; rdy = 1'b0;
      @(negedge clk);
      chk(stall == 1'b1, "R2 stall held with port blocked", {31'd0, stall}, 32'd1);
      @(posedge clk); #1; wr_en = 1'b1; wr_sel = 2'b10; wr_data = 32'h0000_B000;
      @(posedge clk); #1; wr_en = 1'b0; rdy = 1'b1;
      begin
         int cnt = 0;
         for (int k = 0; k < 40 && stall; k++) begin
            @(negedge clk);
            if (valid && rdy) cnt++;
            @(posedge clk); #1;
         end
         chk(cnt == 8, "R11 run unaffected by write during stall", cnt, 8);
      end
      rdy = 1'b0;
      do_write(2'b11, 32'h0000_B020);
      quiet(4, "R11 write during stall did not arm");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule